// File: doc/BRIEF.md
# Layered Write-Protection Controller

This block decides, for every byte address offered to it, whether a write into a 256-byte non-volatile array may be committed. Three things stand in the way of a write: a hardware lock pin that freezes the whole array, and two software flags, a reversible one and a permanent one, that each guard the lower half (addresses 00h to 7Fh). The upper half (80h to FFh) is held back only by the lock pin. Both flags start cleared at reset, which stands for the shipped state of the part.

The block also decodes the bus commands that set, clear and query the protection flags. The surrounding bus logic hands over each received slave-address byte with a strobe. For a protection command the block answers one cycle later with an ACK or NACK decision. A flag-changing command is held pending until the bus STOP. The change then lands when the external programming timer reports that the internal write cycle is over. The pending command moves through three named states. IDLE goes to ARMED on an accepted change command. ARMED goes to PROGRAM on STOP, goes back to IDLE when a different address is strobed, and stays in ARMED when another accepted change command replaces the pending one. PROGRAM goes to IDLE when the programming cycle ends, and the pending change is applied on that transition.

Top module: `wp_guard`

## Requirements
- R1: While `hw_lock` is 1, `wr_allow` is 0 for every address.
- R2: While `hw_lock` is 0, `wr_allow` is 1 for any address whose top bit is 1 (upper half), whatever the flags hold.
- R3: For a lower-half address (top bit 0), `wr_allow` is 1 only when `hw_lock` is 0 and both the reversible and the permanent flag are 0.
- R4: After reset both flags are 0, so a lower-half address with `hw_lock` low is writable, and `cmd_valid` is 0.
- R5: A strobed byte is a reversible command only when `hv_qual` is 1, `pin_a2` is 0, and the byte reads 0110 in bits 7:4, 0 in bit 3, `pin_a1` in bit 2 and 1 in bit 1. It is a permanent command only when `hv_qual` is 0 and bits 7:1 read 0110000. Bit 0 is the read/write bit. Any other byte draws no reply: `cmd_valid` stays 0.
- R6: A reply appears as a one-cycle `cmd_valid` pulse on the cycle after the strobe, with `cmd_ack` = 1 meaning ACK. Reads (bit 0 = 1) change no flag. A reversible read ACKs when the reversible flag is 0, and a permanent read ACKs when the permanent flag is 0.
- R7: A change command (bit 0 = 0) is one of three kinds. A reversible command with bit 2 = 1 sets the reversible flag, one with bit 2 = 0 clears it, and the permanent command sets the permanent flag. Each kind is ACKed when the permanent flag is 0. A NACKed change command alters nothing.
- R8: An accepted change lands only after a STOP followed by `prog_done`. The new flag value shows on `wr_allow` from the cycle after `prog_done` is sampled. Before STOP, a newly strobed change command replaces the pending one, and any other strobe discards it. If STOP and a strobe arrive in the same cycle while a change is pending, STOP wins and the strobe draws no reply.
- R9: Between STOP and `prog_done`, every protection command is answered NACK and changes nothing. A `prog_done` in the same cycle as such a strobe still commits the pending change.
- R10: Once the permanent flag is set it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also returns both flags to 0 |
| hw_lock | input | 1 | Hardware write-lock pin, 1 = whole array read-only |
| hv_qual | input | 1 | High-voltage qualifier seen on the lowest address pin |
| pin_a2 | input | 1 | Logic level of address pin 2 |
| pin_a1 | input | 1 | Logic level of address pin 1 |
| cmd_strobe | input | 1 | One-cycle pulse: `slave_byte` holds a received slave-address byte |
| slave_byte | input | 8 | Received slave-address byte, bit 0 = read/write |
| stop_strobe | input | 1 | One-cycle pulse on a bus STOP |
| prog_done | input | 1 | One-cycle pulse at the end of the internal write cycle |
| wr_addr | input | ADDR_W | Byte address being considered for a write |
| wr_allow | output | 1 | 1 = a write to `wr_addr` may be committed |
| cmd_valid | output | 1 | One-cycle pulse: a protection-command reply is present |
| cmd_ack | output | 1 | Reply value, 1 = ACK, 0 = NACK |

## Verification
Two functions can meet in one cycle. One is the end of the programming cycle, which writes a flag. The other is the reply to a freshly strobed protection command, which reads the flags and the state. The bench provokes the clash on purpose by raising `cmd_strobe` and `prog_done` together while in PROGRAM, and also by raising STOP and a strobe together while ARMED. It then judges the reply, which must be a busy NACK in the first case and no reply in the second, along with `wr_allow` on the following cycles. A cycle-level reference model in the bench also runs long random streams in which these coincidences occur by chance, and the design is compared with the model on every cycle.

// File: rtl/wpg_pkg.sv
package wpg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_PROGRAM
    } wpg_state_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_REV_SET,
        OP_REV_CLR,
        OP_REV_READ,
        OP_PERM_SET,
        OP_PERM_READ
    } wpg_op_e;

    function automatic logic op_changes(input wpg_op_e op);
        return (op == OP_REV_SET) || (op == OP_REV_CLR) || (op == OP_PERM_SET);
    endfunction

endpackage

// File: rtl/wpg_decode.sv
module wpg_decode
    import wpg_pkg::*;
#(
    parameter logic [3:0] PREFIX = 4'b0110
) (
    input  logic [7:0] slave_byte,
    input  logic       hv_qual,
    input  logic       pin_a2,
    input  logic       pin_a1,
    output wpg_op_e    op
);

    logic prefix_hit;
    logic rev_form;
    logic perm_form;

    always_comb begin
        prefix_hit = (slave_byte[7:4] == PREFIX);
        rev_form   = prefix_hit && hv_qual && !pin_a2 && !slave_byte[3]
                     && (slave_byte[2] == pin_a1) && slave_byte[1];
        perm_form  = prefix_hit && !hv_qual && (slave_byte[3:1] == 3'b000);
        op = OP_NONE;
        if (rev_form) begin
            if (slave_byte[0])      op = OP_REV_READ;
            else if (slave_byte[2]) op = OP_REV_SET;
            else                    op = OP_REV_CLR;
        end else if (perm_form) begin
            op = slave_byte[0] ? OP_PERM_READ : OP_PERM_SET;
        end
    end

endmodule

// File: rtl/wpg_ctrl.sv
module wpg_ctrl
    import wpg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_strobe,
    input  wpg_op_e    op,
    input  logic       stop_strobe,
    input  logic       prog_done,
    output wpg_state_e state,
    output logic       perm_flag,
    output logic       rev_flag,
    output logic       cmd_valid,
    output logic       cmd_ack
);

    wpg_state_e st_nx;
    wpg_op_e    pend_q, pend_nx;
    logic       perm_nx, rev_nx;
    logic       accept;
    logic       reply_v, reply_a;

    always_comb begin
        accept = cmd_strobe && op_changes(op) && !perm_flag;
    end

    // next-state and flag commit
    always_comb begin
        st_nx   = state;
        pend_nx = pend_q;
        perm_nx = perm_flag;
        rev_nx  = rev_flag;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    st_nx   = ST_ARMED;
                    pend_nx = op;
                end
            end
            ST_ARMED: begin
                if (stop_strobe) begin
                    st_nx = ST_PROGRAM;
                end else if (cmd_strobe) begin
                    if (accept) pend_nx = op;
                    else        st_nx   = ST_IDLE;
                end
            end
            ST_PROGRAM: begin
                if (prog_done) begin
                    st_nx = ST_IDLE;
                    case (pend_q)
                        OP_REV_SET:  rev_nx  = 1'b1;
                        OP_REV_CLR:  rev_nx  = 1'b0;
                        OP_PERM_SET: perm_nx = 1'b1;
                        default:     ;
                    endcase
                end
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // reply decision
    always_comb begin
        reply_v = cmd_strobe && (op != OP_NONE)
                  && !((state == ST_ARMED) && stop_strobe);
        reply_a = 1'b0;
        if (state != ST_PROGRAM) begin
            case (op)
                OP_REV_READ:  reply_a = !rev_flag;
                OP_NONE:      reply_a = 1'b0;
                default:      reply_a = !perm_flag;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            pend_q    <= OP_NONE;
            perm_flag <= 1'b0;
            rev_flag  <= 1'b0;
        end else begin
            state     <= st_nx;
            pend_q    <= pend_nx;
            perm_flag <= perm_nx;
            rev_flag  <= rev_nx;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_ack   <= 1'b0;
        end else begin
            cmd_valid <= reply_v;
            cmd_ack   <= reply_v && reply_a;
        end
    end

endmodule

// File: rtl/wpg_gate.sv
module wpg_gate #(
    parameter int ADDR_W = 8
) (
    input  logic              hw_lock,
    input  logic              perm_flag,
    input  logic              rev_flag,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              wr_allow
);

    localparam int HALF_BIT = ADDR_W - 1;

    logic upper_half;

    always_comb begin
        upper_half = wr_addr[HALF_BIT];
        wr_allow   = !hw_lock && (upper_half || (!perm_flag && !rev_flag));
    end

endmodule

// File: rtl/wp_guard.sv
module wp_guard
    import wpg_pkg::*;
#(
    parameter int         ADDR_W = 8,
    parameter logic [3:0] PREFIX = 4'b0110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_lock,
    input  logic              hv_qual,
    input  logic              pin_a2,
    input  logic              pin_a1,
    input  logic              cmd_strobe,
    input  logic [7:0]        slave_byte,
    input  logic              stop_strobe,
    input  logic              prog_done,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              wr_allow,
    output logic              cmd_valid,
    output logic              cmd_ack
);

    wpg_op_e    op;
    wpg_state_e state;
    logic       perm_flag;
    logic       rev_flag;

    wpg_decode #(.PREFIX(PREFIX)) u_decode (
        .slave_byte (slave_byte),
        .hv_qual    (hv_qual),
        .pin_a2     (pin_a2),
        .pin_a1     (pin_a1),
        .op         (op)
    );

    wpg_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_strobe  (cmd_strobe),
        .op          (op),
        .stop_strobe (stop_strobe),
        .prog_done   (prog_done),
        .state       (state),
        .perm_flag   (perm_flag),
        .rev_flag    (rev_flag),
        .cmd_valid   (cmd_valid),
        .cmd_ack     (cmd_ack)
    );

    wpg_gate #(.ADDR_W(ADDR_W)) u_gate (
        .hw_lock   (hw_lock),
        .perm_flag (perm_flag),
        .rev_flag  (rev_flag),
        .wr_addr   (wr_addr),
        .wr_allow  (wr_allow)
    );

endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk
    import wpg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hw_lock,
    input logic              cmd_strobe,
    input logic              prog_done,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              wr_allow,
    input logic              cmd_valid,
    input logic              cmd_ack,
    input wpg_state_e        st,
    input logic              perm_flag,
    input logic              rev_flag
);

    AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        hw_lock |-> !wr_allow); // R1

    AST_UPPER_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_lock && wr_addr[ADDR_W-1]) |-> wr_allow); // R2

    AST_LOWER_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_addr[ADDR_W-1] && (perm_flag || rev_flag)) |-> !wr_allow); // R3

    AST_REPLY_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(cmd_strobe)); // R6

    AST_FLAGS_WAIT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !((st == ST_PROGRAM) && prog_done) |=> ($stable(rev_flag) && $stable(perm_flag))); // R8

    AST_BUSY_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_PROGRAM) && cmd_strobe) |=> !cmd_ack); // R9

    AST_PERM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        perm_flag |=> perm_flag); // R10

endmodule

bind wp_guard wp_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hw_lock    (hw_lock),
    .cmd_strobe (cmd_strobe),
    .prog_done  (prog_done),
    .wr_addr    (wr_addr),
    .wr_allow   (wr_allow),
    .cmd_valid  (cmd_valid),
    .cmd_ack    (cmd_ack),
    .st         (state),
    .perm_flag  (perm_flag),
    .rev_flag   (rev_flag)
);

// File: tb/wp_guard_tb_top.sv
`timescale 1ns/1ps
module wp_guard_tb_top;

    localparam int M_IDLE = 0, M_ARMED = 1, M_PROG = 2;
    localparam int K_NONE = 0, K_RSET = 1, K_RCLR = 2, K_RREAD = 3, K_PSET = 4, K_PREAD = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_lock = 1'b0, hv_qual = 1'b0, pin_a2 = 1'b0, pin_a1 = 1'b0;
    logic       cmd_strobe = 1'b0, stop_strobe = 1'b0, prog_done = 1'b0;
    logic [7:0] slave_byte = 8'h00;
    logic [7:0] wr_addr = 8'h00;
    logic       wr_allow, cmd_valid, cmd_ack;

    int checks = 0;
    int errors = 0;

    int  m_st;
    int  m_pend;
    bit  m_perm, m_rev;
    bit  e_valid, e_ack;
    string e_tag;

    always #2.5 clk = ~clk;

    wp_guard dut_i (
        .clk(clk), .rst_n(rst_n), .hw_lock(hw_lock), .hv_qual(hv_qual),
        .pin_a2(pin_a2), .pin_a1(pin_a1), .cmd_strobe(cmd_strobe),
        .slave_byte(slave_byte), .stop_strobe(stop_strobe), .prog_done(prog_done),
        .wr_addr(wr_addr), .wr_allow(wr_allow), .cmd_valid(cmd_valid), .cmd_ack(cmd_ack)
    );

    function automatic int kind_of(logic [7:0] b, logic hv, logic a2, logic a1);
        if (b[7:4] != 4'b0110) return K_NONE;
        if (hv) begin
            if (a2 || b[3] || (b[2] != a1) || !b[1]) return K_NONE;
            if (b[0]) return K_RREAD;
            return b[2] ? K_RSET : K_RCLR;
        end
        if (b[3:1] != 3'b000) return K_NONE;
        return b[0] ? K_PREAD : K_PSET;
    endfunction

    function automatic bit exp_allow(logic hw, logic [7:0] a, bit pf, bit rf);
        if (hw) return 1'b0;           // R1
        if (a[7]) return 1'b1;         // R2
        return !pf && !rf;             // R3
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_st = M_IDLE; m_pend = K_NONE; m_perm = 1'b0; m_rev = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cmd_strobe = 0; stop_strobe = 0; prog_done = 0;
        hw_lock = 0; hv_qual = 0; wr_addr = 8'h10;
        model_reset();
        repeat (2) @(negedge clk);
        chk("R4 reset cmd_valid", cmd_valid, 1'b0);
        chk("R4 reset lower writable", wr_allow, 1'b1);
        rst_n = 1'b1;
    endtask

    task automatic step(logic hw, logic hv, logic a2, logic a1, logic stb,
                        logic [7:0] sb, logic stp, logic pd, logic [7:0] ad);
        int  k;
        bit  acc;
        @(negedge clk);
        hw_lock = hw; hv_qual = hv; pin_a2 = a2; pin_a1 = a1;
        cmd_strobe = stb; slave_byte = sb; stop_strobe = stp; prog_done = pd; wr_addr = ad;
        k   = kind_of(sb, hv, a2, a1);
        acc = stb && (k == K_RSET || k == K_RCLR || k == K_PSET) && !m_perm;
        e_valid = stb && (k != K_NONE) && !(m_st == M_ARMED && stp);
        e_ack   = 1'b0;
        if (m_st != M_PROG) e_ack = (k == K_RREAD) ? !m_rev : !m_perm;
        if (k == K_NONE) e_ack = 1'b0;
        e_ack = e_ack && e_valid;
        if (m_st == M_PROG && stb)                  e_tag = "R9 busy reply";
        else if (m_st == M_ARMED && stp && stb)     e_tag = "R8 stop beats strobe";
        else if (k == K_PREAD && m_perm)            e_tag = "R10 perm stays set";
        else if (k == K_RREAD || k == K_PREAD)      e_tag = "R6 read reply";
        else if (k != K_NONE)                       e_tag = "R7 change reply";
        else                                        e_tag = "R5 no reply";
        @(posedge clk);
        case (m_st)
            M_IDLE:  if (acc) begin m_st = M_ARMED; m_pend = k; end
            M_ARMED: if (stp) m_st = M_PROG;
                     else if (stb) begin
                         if (acc) m_pend = k;
                         else     m_st = M_IDLE;
                     end
            default: if (pd) begin
                         m_st = M_IDLE;
                         if (m_pend == K_RSET) m_rev = 1'b1;
                         if (m_pend == K_RCLR) m_rev = 1'b0;
                         if (m_pend == K_PSET) m_perm = 1'b1;
                     end
        endcase
        #1;
        chk({e_tag, " valid"}, cmd_valid, e_valid);
        if (e_valid) chk({e_tag, " ack"}, cmd_ack, e_ack);
        chk(hw ? "R1 lock" : (ad[7] ? "R2 upper" : "R3 lower"),
            wr_allow, exp_allow(hw, ad, m_perm, m_rev));
    endtask

    task automatic idle(logic [7:0] ad);
        step(0, 0, 0, 0, 0, 8'h00, 0, 0, ad);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        do_reset();
        // directed: reversible set, held until STOP and prog_done (R8)
        step(0, 1, 0, 1, 1, 8'b0110_0110, 0, 0, 8'h05);   // set rev, R7 ACK
        idle(8'h05);                                     // still writable, R8
        step(0, 1, 0, 1, 1, 8'b0110_0110, 0, 0, 8'h05);   // replace pending
        step(0, 0, 0, 0, 0, 8'h00, 1, 0, 8'h05);          // STOP -> PROGRAM
        idle(8'h05);
        // busy strobe and prog_done together (R9)
        step(0, 1, 0, 1, 1, 8'b0110_0111, 0, 1, 8'h05);
        idle(8'h05);                                     // lower now blocked, R3
        idle(8'h85);                                     // upper open, R2
        step(1, 0, 0, 0, 0, 8'h00, 0, 0, 8'h85);          // lock, R1
        step(0, 1, 0, 0, 1, 8'b0110_0011, 0, 0, 8'h20);   // rev read NACK, R6
        // wrong pin match: no reply (R5)
        step(0, 1, 1, 0, 1, 8'b0110_0010, 0, 0, 8'h20);
        step(0, 0, 0, 0, 1, 8'b0110_0011, 0, 0, 8'h20);
        // clear rev, with STOP and strobe colliding in ARMED (R8)
        step(0, 1, 0, 0, 1, 8'b0110_0010, 0, 0, 8'h20);
        step(0, 1, 0, 0, 1, 8'b0110_0110, 1, 0, 8'h20);
        step(0, 0, 0, 0, 0, 8'h00, 0, 1, 8'h20);
        idle(8'h20);
        // permanent set and sticky behaviour (R10)
        step(0, 0, 0, 0, 1, 8'b0110_0000, 0, 0, 8'h30);
        step(0, 0, 0, 0, 0, 8'h00, 1, 0, 8'h30);
        step(0, 0, 0, 0, 0, 8'h00, 0, 1, 8'h30);
        step(0, 1, 0, 0, 1, 8'b0110_0010, 0, 0, 8'h30);   // clear refused
        step(0, 0, 0, 0, 0, 8'h00, 1, 0, 8'h30);
        step(0, 0, 0, 0, 0, 8'h00, 0, 1, 8'h30);
        step(0, 0, 0, 0, 1, 8'b0110_0001, 0, 0, 8'h30);   // perm read NACK
        idle(8'h30);
        // random phases
        for (int ph = 0; ph < 4; ph++) begin
            do_reset();
            for (int n = 0; n < 3000; n++) begin
                logic       hv, a2, a1, stb, rw;
                logic [7:0] sb;
                int         mode;
                hv  = $urandom_range(0, 1);
                a2  = ($urandom_range(0, 7) == 0);
                a1  = $urandom_range(0, 1);
                stb = ($urandom_range(0, 3) == 0);
                mode = $urandom_range(0, 3);
                if (mode < 2) begin
                    rw = $urandom_range(0, 1);
                    sb = {4'b0110, 1'b0, a1, 1'b1, rw};
                end else if (mode == 2) begin
                    rw = ($urandom_range(0, 15) != 0);
                    sb = {7'b0110000, rw};
                end else begin
                    sb = 8'($urandom);
                end
                step(($urandom_range(0, 3) == 0), hv, a2, a1, stb, sb,
                     ($urandom_range(0, 5) == 0), ($urandom_range(0, 4) == 0),
                     8'($urandom));
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule